// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home agent for a slice of distributed shared memory. For every memory line it owns, it keeps a directory entry that holds a line state (uncached, shared or exclusive) and a sharer vector with one bit per cache. Caches send it three kinds of request: a read miss, a write miss, or a writeback of a dirty line. Each request carries a line index and the ID of the requesting cache.

The controller takes one request at a time. It looks up the entry and emits the messages that the current state requires. These can be an owner fetch, an owner fetch-and-invalidate, or a series of invalidations to the sharers. The last message is always the data reply to the requester, and the entry is rewritten as that reply is accepted.

Messages leave on a single valid/ready stream. The block holds off new requests until the whole message sequence for the current one has drained. The interconnect, the line data and the cache-side controllers lie outside this block.

Top module: `dir_coherence_ctrl`

## Requirements
- R1: After reset every line is uncached with an empty sharer vector, reqReady is 1 and msgValid is 0.
- R2: A read miss (reqType 0) from cache c to an uncached line produces exactly one data reply (msgType 0) to c. The line becomes shared with sharers {c}.
- R3: A read miss from c to a shared line produces one data reply to c. c is added to the sharers and the line stays shared.
- R4: A read miss from c to an exclusive line first sends a fetch (msgType 1) to the owner and then a data reply to c. The line becomes shared with sharers {owner, c}.
- R5: A write miss (reqType 1) from c to an uncached line produces one data reply to c. The line becomes exclusive with sharers {c}.
- R6: A write miss from c to a shared line sends an invalidation (msgType 3) to every sharer except c, in ascending cache-ID order, one per accepted message. A data reply to c follows, and the line becomes exclusive with sharers {c}.
- R7: A write miss from c to an exclusive line sends a fetch-and-invalidate (msgType 2) to the owner and then a data reply to c. The line becomes exclusive with sharers {c}, and an exclusive line always records exactly one sharer.
- R8: A writeback (reqType 2) from the recorded owner of an exclusive line emits no message. The line becomes uncached with an empty sharer vector.
- R9: A writeback from any cache that is not the recorded exclusive owner emits no message and leaves the entry unchanged.
- R10: reqReady is 0 from the cycle after a request is accepted until its last message has been accepted, and no message is offered while reqReady is 1.
- R11: While msgValid is 1 and msgReady is 0, msgValid, msgType, msgDest and msgLine hold their values into the next cycle.
- R12: Request code 3 is ignored: it emits no message and changes no entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Controller can take a request |
| reqType | input | 2 | 0 read miss, 1 write miss, 2 writeback, 3 ignored |
| reqLine | input | $clog2(NUM_LINES) | Line index |
| reqCache | input | $clog2(NUM_CACHES) | Requesting cache ID |
| msgValid | output | 1 | Outgoing message present |
| msgReady | input | 1 | Network accepts the message |
| msgType | output | 2 | 0 data reply, 1 fetch, 2 fetch-and-invalidate, 3 invalidate |
| msgLine | output | $clog2(NUM_LINES) | Line the message refers to |
| msgDest | output | $clog2(NUM_CACHES) | Destination cache ID |

## Verification
The bench targets invalidation fan-out where the requester is itself a sharer. A design that failed to skip it would send the writer an invalidation, and one that scanned in the wrong direction would emit the IDs in descending order. Writebacks from a non-owner are followed by a read to the same line: if the design had wrongly cleared the entry, the expected owner fetch would not appear. Under periodic backpressure, a message that changes while stalled, or an invalidation that is dropped, shows up as a mismatch against the scoreboard queue.

// File: rtl/dir_pkg.sv
package dir_pkg;

  typedef enum logic [1:0] {
    REQ_READ  = 2'd0,
    REQ_WRITE = 2'd1,
    REQ_WBACK = 2'd2,
    REQ_NONE  = 2'd3
  } reqKind_e;

  typedef enum logic [1:0] {
    MSG_DATA      = 2'd0,
    MSG_FETCH     = 2'd1,
    MSG_FETCH_INV = 2'd2,
    MSG_INVAL     = 2'd3
  } msgKind_e;

  typedef enum logic [1:0] {
    LINE_UNCACHED = 2'd0,
    LINE_SHARED   = 2'd1,
    LINE_EXCL     = 2'd2
  } lineState_e;

  typedef enum logic [1:0] {
    DEST_REQ   = 2'd0,
    DEST_OWNER = 2'd1,
    DEST_INV   = 2'd2
  } destSel_e;

  // strobes from the sequencer to the directory datapath
  typedef struct packed {
    logic     capture;     // latch request and read its entry
    logic     loadInv;     // arm invalidation mask
    logic     popInv;      // lowest pending invalidation was accepted
    logic     commitFill;  // rewrite entry after data reply
    logic     commitEvict; // clear entry after owner writeback
    destSel_e destSel;
  } dpStrobe_t;

endpackage

// File: rtl/dir_datapath.sv
module dir_datapath
  import dir_pkg::*;
#(
  parameter int NUM_CACHES = 8,
  parameter int NUM_LINES  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [1:0]                    reqType,
  input  logic [$clog2(NUM_LINES)-1:0]  reqLine,
  input  logic [$clog2(NUM_CACHES)-1:0] reqCache,
  input  dpStrobe_t                     strobe,
  output reqKind_e                      workKind,
  output lineState_e                    workState,
  output logic                          ownerMatch,
  output logic                          othersShare,
  output logic                          invLast,
  output logic [$clog2(NUM_LINES)-1:0]  msgLine,
  output logic [$clog2(NUM_CACHES)-1:0] msgDest
);
  localparam int ID_W   = $clog2(NUM_CACHES);
  localparam int LINE_W = $clog2(NUM_LINES);

  lineState_e            entState [NUM_LINES];
  logic [NUM_CACHES-1:0] entShare [NUM_LINES];

  logic [LINE_W-1:0]     workLine;
  logic [ID_W-1:0]       workCache;
  logic [NUM_CACHES-1:0] workShare;
  logic [NUM_CACHES-1:0] invMask;
  logic [NUM_CACHES-1:0] reqBit;
  logic [ID_W-1:0]       ownerIdx;
  logic [ID_W-1:0]       invIdx;

  assign reqBit = NUM_CACHES'(1) << workCache;

  // lowest set bit of the recorded sharers and of the pending mask
  always_comb begin
    ownerIdx = '0;
    for (int i = NUM_CACHES - 1; i >= 0; i--)
      if (workShare[i]) ownerIdx = ID_W'(i);
  end

  always_comb begin
    invIdx = '0;
    for (int i = NUM_CACHES - 1; i >= 0; i--)
      if (invMask[i]) invIdx = ID_W'(i);
  end

  assign ownerMatch  = (workState == LINE_EXCL) && (workShare == reqBit);
  assign othersShare = |(workShare & ~reqBit);
  assign invLast     = ((invMask & (invMask - NUM_CACHES'(1))) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      workLine  <= '0;
      workCache <= '0;
      workKind  <= REQ_NONE;
      workState <= LINE_UNCACHED;
      workShare <= '0;
      invMask   <= '0;
      for (int i = 0; i < NUM_LINES; i++) begin
        entState[i] <= LINE_UNCACHED;
        entShare[i] <= '0;
      end
    end else begin
      if (strobe.capture) begin
        workLine  <= reqLine;
        workCache <= reqCache;
        workKind  <= reqKind_e'(reqType);
        workState <= entState[reqLine];
        workShare <= entShare[reqLine];
      end
      if (strobe.loadInv)
        invMask <= workShare & ~reqBit;
      else if (strobe.popInv)
        invMask <= invMask & ~(NUM_CACHES'(1) << invIdx);
      if (strobe.commitFill) begin
        if (workKind == REQ_WRITE) begin
          entState[workLine] <= LINE_EXCL;
          entShare[workLine] <= reqBit;
        end else begin
          entState[workLine] <= LINE_SHARED;
          entShare[workLine] <= (workState == LINE_UNCACHED) ? reqBit
                                                              : (workShare | reqBit);
        end
      end else if (strobe.commitEvict) begin
        entState[workLine] <= LINE_UNCACHED;
        entShare[workLine] <= '0;
      end
    end
  end

  assign msgLine = workLine;

  always_comb begin
    unique case (strobe.destSel)
      DEST_OWNER: msgDest = ownerIdx;
      DEST_INV:   msgDest = invIdx;
      default:    msgDest = workCache;
    endcase
  end

  // R6: the writer never receives an invalidation for its own miss
  assert_inval_skips_writer_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popInv |-> (invIdx != workCache));

  // R6: invalidations leave in ascending ID order
  assert_inval_ascending_R6: assert property (@(posedge clk) disable iff (!rstN)
    strobe.popInv |=> ((invMask == '0) || (invIdx > $past(invIdx))));

  // R7: an exclusive entry read from the directory names exactly one cache
  assert_excl_single_owner_R7: assert property (@(posedge clk) disable iff (!rstN)
    (workState == LINE_EXCL) |-> $onehot(workShare));

endmodule

// File: rtl/dir_control.sv
module dir_control
  import dir_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  output logic       msgValid,
  input  logic       msgReady,
  output logic [1:0] msgType,
  input  reqKind_e   workKind,
  input  lineState_e workState,
  input  logic       ownerMatch,
  input  logic       othersShare,
  input  logic       invLast,
  output dpStrobe_t  strobe
);
  typedef enum logic [2:0] {
    S_IDLE, S_EVAL, S_FETCH, S_FETCH_INV, S_INVAL, S_DATA
  } seqState_e;

  seqState_e state, stateNext;
  msgKind_e  kind;

  assign reqReady = (state == S_IDLE);
  assign msgType  = kind;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    msgValid  = 1'b0;
    kind      = MSG_DATA;
    strobe.destSel = DEST_REQ;
    unique case (state)
      S_IDLE: begin
        strobe.capture = reqValid;
        if (reqValid) stateNext = S_EVAL;
      end
      S_EVAL: begin
        unique case (workKind)
          REQ_READ:
            stateNext = (workState == LINE_EXCL) ? S_FETCH : S_DATA;
          REQ_WRITE: begin
            if (workState == LINE_EXCL)
              stateNext = S_FETCH_INV;
            else if (workState == LINE_SHARED && othersShare) begin
              strobe.loadInv = 1'b1;
              stateNext      = S_INVAL;
            end else
              stateNext = S_DATA;
          end
          REQ_WBACK: begin
            strobe.commitEvict = ownerMatch;
            stateNext          = S_IDLE;
          end
          default: stateNext = S_IDLE;
        endcase
      end
      S_FETCH: begin
        msgValid       = 1'b1;
        kind           = MSG_FETCH;
        strobe.destSel = DEST_OWNER;
        if (msgReady) stateNext = S_DATA;
      end
      S_FETCH_INV: begin
        msgValid       = 1'b1;
        kind           = MSG_FETCH_INV;
        strobe.destSel = DEST_OWNER;
        if (msgReady) stateNext = S_DATA;
      end
      S_INVAL: begin
        msgValid       = 1'b1;
        kind           = MSG_INVAL;
        strobe.destSel = DEST_INV;
        strobe.popInv  = msgReady;
        if (msgReady && invLast) stateNext = S_DATA;
      end
      S_DATA: begin
        msgValid          = 1'b1;
        kind              = MSG_DATA;
        strobe.commitFill = msgReady;
        if (msgReady) stateNext = S_IDLE;
      end
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= stateNext;
  end

  // R11: a stalled message is not withdrawn or altered
  assert_msg_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> (msgValid && $stable(msgType) && $stable(strobe.destSel)));

  // R10: requests are only taken when no message is in flight
  assert_no_msg_when_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> !msgValid);

  // R10: an accepted request closes the request port on the next cycle
  assert_stall_after_accept_R10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

// File: rtl/dir_coherence_ctrl.sv
module dir_coherence_ctrl
  import dir_pkg::*;
#(
  parameter int NUM_CACHES = 8,
  parameter int NUM_LINES  = 16
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [1:0]                    reqType,
  input  logic [$clog2(NUM_LINES)-1:0]  reqLine,
  input  logic [$clog2(NUM_CACHES)-1:0] reqCache,
  output logic                          msgValid,
  input  logic                          msgReady,
  output logic [1:0]                    msgType,
  output logic [$clog2(NUM_LINES)-1:0]  msgLine,
  output logic [$clog2(NUM_CACHES)-1:0] msgDest
);
  dpStrobe_t  strobe;
  reqKind_e   workKind;
  lineState_e workState;
  logic       ownerMatch;
  logic       othersShare;
  logic       invLast;

  dir_control u_ctrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady),
    .msgValid(msgValid), .msgReady(msgReady), .msgType(msgType),
    .workKind(workKind), .workState(workState),
    .ownerMatch(ownerMatch), .othersShare(othersShare), .invLast(invLast),
    .strobe(strobe)
  );

  dir_datapath #(.NUM_CACHES(NUM_CACHES), .NUM_LINES(NUM_LINES)) u_dp (
    .clk(clk), .rstN(rstN),
    .reqType(reqType), .reqLine(reqLine), .reqCache(reqCache),
    .strobe(strobe),
    .workKind(workKind), .workState(workState),
    .ownerMatch(ownerMatch), .othersShare(othersShare), .invLast(invLast),
    .msgLine(msgLine), .msgDest(msgDest)
  );

  // R11: destination and line hold while the network stalls
  assert_dest_held_R11: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !msgReady) |=> ($stable(msgDest) && $stable(msgLine)));

endmodule

// File: tb/dir_coherence_ctrl_test.sv
module dir_coherence_ctrl_test;
  localparam int NC = 8;
  localparam int NL = 16;
  localparam int IW = $clog2(NC);
  localparam int LW = $clog2(NL);

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [1:0] reqType = '0;
  logic [LW-1:0] reqLine = '0;
  logic [IW-1:0] reqCache = '0;
  logic msgValid;
  logic msgReady = 1'b1;
  logic [1:0] msgType;
  logic [LW-1:0] msgLine;
  logic [IW-1:0] msgDest;

  always #10 clk = ~clk;

  dir_coherence_ctrl #(.NUM_CACHES(NC), .NUM_LINES(NL)) uut (.*);

  int checks = 0;
  int fails  = 0;
  logic stallOn = 1'b0;
  int cyc = 0;

  // reference directory: 0 uncached, 1 shared, 2 exclusive
  int            mState [NL];
  logic [NC-1:0] mShare [NL];

  typedef struct { logic [1:0] t; int dest; int line; string req; } expMsg_t;
  expMsg_t expQ[$];

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic void pushMsg(input logic [1:0] t, input int d, input int l,
                                  input string r);
    expMsg_t m;
    m.t = t; m.dest = d; m.line = l; m.req = r;
    expQ.push_back(m);
  endfunction

  function automatic int lowest(input logic [NC-1:0] v);
    for (int i = 0; i < NC; i++) if (v[i]) return i;
    return 0;
  endfunction

  // expected messages and entry update straight from the requirements
  function automatic void model(input int t, input int l, input int c);
    logic [NC-1:0] cb;
    cb = NC'(1) << c;
    case (t)
      0: begin
        if (mState[l] == 2) begin
          pushMsg(2'd1, lowest(mShare[l]), l, "R4");
          pushMsg(2'd0, c, l, "R4");
          mShare[l] = mShare[l] | cb;
        end else if (mState[l] == 1) begin
          pushMsg(2'd0, c, l, "R3");
          mShare[l] = mShare[l] | cb;
        end else begin
          pushMsg(2'd0, c, l, "R2");
          mShare[l] = cb;
        end
        mState[l] = 1;
      end
      1: begin
        if (mState[l] == 2) begin
          pushMsg(2'd2, lowest(mShare[l]), l, "R7");
          pushMsg(2'd0, c, l, "R7");
        end else if (mState[l] == 1) begin
          for (int i = 0; i < NC; i++)
            if (mShare[l][i] && i != c) pushMsg(2'd3, i, l, "R6");
          pushMsg(2'd0, c, l, "R6");
        end else
          pushMsg(2'd0, c, l, "R5");
        mState[l] = 2;
        mShare[l] = cb;
      end
      2: begin
        if (mState[l] == 2 && mShare[l] == cb) begin
          mState[l] = 0;
          mShare[l] = '0;
        end
      end
      default: ;
    endcase
  endfunction

  task automatic sendReq(input int t, input int l, input int c);
    model(t, l, c);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    reqType  = 2'(t);
    reqLine  = LW'(l);
    reqCache = IW'(c);
    @(negedge clk);
    reqValid = 1'b0;
    check(reqReady == 1'b0, "R10", "reqReady after accept", int'(reqReady), 0);
  endtask

  task automatic drain();
    int guard = 0;
    @(negedge clk);
    while ((expQ.size() != 0 || !reqReady) && guard < 2000) begin
      @(negedge clk);
      guard++;
    end
    check(expQ.size() == 0, "R10", "pending expected messages", expQ.size(), 0);
  endtask

  // backpressure generator
  always @(posedge clk) begin
    cyc <= cyc + 1;
    #1 msgReady = stallOn ? ((cyc % 3) == 0) : 1'b1;
  end

  // monitor: compare accepted messages; check stability under stall
  logic       heldV = 1'b0;
  logic [1:0] heldT;
  logic [IW-1:0] heldD;
  logic [LW-1:0] heldL;
  always @(negedge clk) begin
    if (rstN) begin
      if (heldV)
        check(msgValid && msgType == heldT && msgDest == heldD && msgLine == heldL,
              "R11", "stalled message changed", int'(msgDest), int'(heldD));
      heldV = msgValid && !msgReady;
      heldT = msgType; heldD = msgDest; heldL = msgLine;
      if (msgValid && msgReady) begin
        if (expQ.size() == 0)
          check(1'b0, "R12", "unexpected message type", int'(msgType), -1);
        else begin
          expMsg_t e;
          e = expQ.pop_front();
          check(msgType == e.t, e.req, "msgType", int'(msgType), int'(e.t));
          check(int'(msgDest) == e.dest, e.req, "msgDest", int'(msgDest), e.dest);
          check(int'(msgLine) == e.line, e.req, "msgLine", int'(msgLine), e.line);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < NL; i++) begin mState[i] = 0; mShare[i] = '0; end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(reqReady == 1'b1, "R1", "reqReady after reset", int'(reqReady), 1);
    check(msgValid == 1'b0, "R1", "msgValid after reset", int'(msgValid), 0);

    sendReq(0, 0, 3); drain();          // R2 uncached read
    sendReq(0, 0, 5); drain();          // R3 shared read
    sendReq(0, 0, 0); drain();          // R3
    sendReq(1, 0, 5); drain();          // R6: inval 0,3 skip 5
    sendReq(2, 0, 2); drain();          // R9 non-owner writeback
    sendReq(0, 0, 1); drain();          // R4 fetch from 5 proves R9 entry kept
    sendReq(1, 1, 7); drain();          // R5
    sendReq(1, 1, 2); drain();          // R7 fetch-inv to 7
    sendReq(2, 1, 7); drain();          // R9 stale owner
    sendReq(2, 1, 2); drain();          // R8 owner writeback
    sendReq(0, 1, 4); drain();          // R2 again: line must be uncached
    sendReq(3, 0, 6); drain();          // R12 ignored code
    stallOn = 1'b1;
    sendReq(1, 0, 7); drain();          // R6 + R11: inval 1,5 under stall
    stallOn = 1'b0;
    sendReq(0, 2, 6); drain();
    sendReq(1, 2, 6); drain();          // R6: sole sharer is writer, data only
    for (int c = 0; c < NC; c++) begin sendReq(0, 3, c); drain(); end
    stallOn = 1'b1;
    sendReq(1, 3, 0); drain();          // R6: 7 invalidations ascending
    sendReq(0, 3, 4); drain();          // R4 + R11
    stallOn = 1'b0;
    sendReq(2, 3, 0); drain();          // R9: line shared, not exclusive
    sendReq(1, 3, 2); drain();          // R6 on {0,4} proves R9

    repeat (5) @(negedge clk);
    check(msgValid == 1'b0, "R10", "idle after all requests", int'(msgValid), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule